// File: doc/BRIEF.md
# Supply Channel Control Register Slave

This block is a two-wire serial slave that owns one byte of control and status for a single supply channel. The bus clock and data lines are oversampled in the system clock domain. The block detects start and stop conditions and collects the address byte. When the address matches, it accepts register writes or returns the register byte for reads. It acknowledges by pulling the data line low through an open-drain enable.

The upper six bits of the byte are control bits that the host writes. They drive the channel outputs `ctrl_out[5:0]`: current-limit mode, transmit-path enable, tone enable, line-drop boost, voltage select and channel enable, from bit 7 down to bit 2. The lower two bits are live diagnostic inputs: over-temperature on bit 1 and overload on bit 0. A write never changes them. A supply-good input gates the slave. While it is low, the slave acknowledges nothing and keeps the control bits cleared.

The byte engine is a state machine with these states:
- `ST_IDLE`: no transfer is active.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the slave drives the acknowledge for a matched address.
- `ST_WR_DATA`: a data byte is being shifted in.
- `ST_WR_ACK`: the slave drives the acknowledge for a data byte.
- `ST_RD_DATA`: the register byte is being shifted out.
- `ST_RD_ACK`: the master's acknowledge slot is sampled.
- `ST_SKIP`: the slave ignores the bus until the next start or stop.

The transitions are:
- Any state goes to `ST_IDLE` on a stop or on low supply.
- Any state goes to `ST_ADDR` on a start.
- `ST_ADDR` goes to `ST_ADDR_ACK` after eight bits on a match, and to `ST_SKIP` otherwise.
- `ST_ADDR_ACK` goes to `ST_WR_DATA` or `ST_RD_DATA`, chosen by the direction bit.
- `ST_WR_DATA` goes to `ST_WR_ACK` after eight bits, and the register is written at that point.
- `ST_WR_ACK` goes back to `ST_WR_DATA`.
- `ST_RD_DATA` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_DATA` when the master acknowledges, and to `ST_SKIP` when it does not.

Top module: `supply_ctl_i2c`

## Requirements
- R1: The slave answers only the 7-bit address {00010, addr_sel[1:0]}, that is 0x08 to 0x0B. It drives the acknowledge low on a match and leaves the line released on any other address.
- R2: Bit 0 of the address byte (the last bit sent) gives the direction: 0 is a write and 1 is a read. With addr_sel = 0, the address byte is 0x10 for a write and 0x11 for a read.
- R3: A written data byte updates ctrl_out with its bits 7:2. Its bits 1:0 are discarded, and reading back shows the flag inputs in those positions instead.
- R4: A read sends {ctrl_out[5:0], flag_hot, flag_ovl}, most significant bit first.
- R5: When the master acknowledges a read byte, the slave sends another byte. When the master does not acknowledge, the slave stops driving until the next start.
- R6: While supply_ok is low, ctrl_out is held at 0 and no byte is acknowledged. This includes an address that would otherwise match.
- R7: After reset, ctrl_out is 0 and sda_oe is 0.
- R8: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start in the middle of a byte restarts address reception, and a stop returns the slave to idle.
- R9: sda_oe changes only while SCL is low.
- R10: In a write with several data bytes, each acknowledged byte updates ctrl_out in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 2 | Low two bits of the slave address |
| supply_ok | input | 1 | Supply above threshold; 0 disables the slave |
| flag_hot | input | 1 | Over-temperature flag, read in bit 1 |
| flag_ovl | input | 1 | Overload flag, read in bit 0 |
| ctrl_out | output | 6 | Control bits 7:2 of the register |

## Verification
Two functions can fall in the same system cycle. The first is the register write on the last falling clock edge of a data byte. The second is the supply-good input dropping, which must clear the register and force the engine idle. The bench drops supply before a transfer and also runs a write while supply is low. It then checks that the control outputs read zero, that the address is not acknowledged, and that a write after supply returns works again. The checker requires a clear one cycle after any cycle with low supply, whatever the engine was doing.

// File: rtl/supply_ctl_pkg.sv
package supply_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ch;
    logic [STAGES-1:0] sda_ch;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ch <= '1;
            sda_ch <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ch <= {scl_ch[STAGES-2:0], scl_in};
            sda_ch <= {sda_ch[STAGES-2:0], sda_in};
            scl_q  <= scl_ch[STAGES-1];
            sda_q  <= sda_ch[STAGES-1];
        end
    end

    always_comb begin
        scl_lvl   = scl_ch[STAGES-1];
        sda_lvl   = sda_ch[STAGES-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
    parameter int CTRL_W = 6,
    parameter int FLAG_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     supply_ok,
    input  logic                     wr_en,
    input  logic [CTRL_W-1:0]        wr_ctrl,
    input  logic [FLAG_W-1:0]        flags,
    output logic [CTRL_W-1:0]        ctrl_q,
    output logic [CTRL_W+FLAG_W-1:0] rd_byte
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (!supply_ok) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_ctrl;
        end
    end

    assign rd_byte = {ctrl_q, flags};
endmodule

// File: rtl/supply_ctl_i2c.sv
module supply_ctl_i2c #(
    parameter int         BYTE_W  = 8,
    parameter int         SEL_W   = 2,
    parameter int         ADDR_W  = 7,
    parameter int         FLAG_W  = 2,
    parameter logic [4:0] ADDR_HI = 5'b00010
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_oe,
    input  logic [SEL_W-1:0]          addr_sel,
    input  logic                      supply_ok,
    input  logic                      flag_hot,
    input  logic                      flag_ovl,
    output logic [BYTE_W-FLAG_W-1:0]  ctrl_out
);
    import supply_ctl_pkg::*;

    localparam int CTRL_W = BYTE_W - FLAG_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    bus_state_t       st, nxt;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, rd_byte;
    logic             m_ack, wr_en, addr_hit;

    ctl_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    ctl_reg_bank #(.CTRL_W(CTRL_W), .FLAG_W(FLAG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_en(wr_en),
        .wr_ctrl(rx_sh[BYTE_W-1:FLAG_W]), .flags({flag_hot, flag_ovl}),
        .ctrl_q(ctrl_out), .rd_byte(rd_byte)
    );

    assign addr_hit = (rx_sh[BYTE_W-1:1] == {ADDR_HI, addr_sel});

    // next-state logic
    always_comb begin
        nxt = st;
        if (!supply_ok) begin
            nxt = ST_IDLE;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else if (start_evt) begin
            nxt = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && cnt == LAST_RX)
                                 nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)
                                 nxt = rx_sh[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && cnt == LAST_RX) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && cnt == LAST_TX) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = m_ack ? ST_RD_DATA : ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // shift and count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '1;
            m_ack <= 1'b0;
        end else if (start_evt || nxt != st) begin
            cnt <= '0;
            if (nxt == ST_RD_DATA) tx_sh <= rd_byte;
        end else if ((st == ST_ADDR || st == ST_WR_DATA) && scl_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
        end else if (st == ST_RD_DATA && scl_fall) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            cnt   <= cnt + 1'b1;
        end else if (st == ST_RD_ACK && scl_rise) begin
            m_ack <= ~sda_lvl;
        end
    end

    // outputs
    always_comb begin
        wr_en  = (st == ST_WR_DATA) && (nxt == ST_WR_ACK);
        sda_oe = (st == ST_ADDR_ACK) || (st == ST_WR_ACK) ||
                 ((st == ST_RD_DATA) && !tx_sh[BYTE_W-1]);
    end
endmodule

// File: rtl/supply_ctl_checks.sv
module supply_ctl_checks
    import supply_ctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       sda_oe,
    input logic [5:0] ctrl_out,
    input logic       scl_lvl,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       wr_en,
    input bus_state_t st
);
    p_reg_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> ctrl_out == 6'd0);

    p_quiet_low_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!supply_ok) |-> !sda_oe);

    p_stop_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && supply_ok) |=> st == ST_IDLE);

    p_start_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && supply_ok) |=> st == ST_ADDR);

    p_write_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st == ST_WR_ACK);

    p_drive_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    p_drive_fall_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_lvl);
endmodule

bind supply_ctl_i2c supply_ctl_checks u_checks (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_oe(sda_oe),
    .ctrl_out(ctrl_out), .scl_lvl(scl_lvl), .start_evt(start_evt),
    .stop_evt(stop_evt), .wr_en(wr_en), .st(st)
);

// File: tb/supply_ctl_i2c_test.sv
module supply_ctl_i2c_test;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic       supply_ok = 1'b1;
    logic       flag_hot = 1'b0;
    logic       flag_ovl = 1'b0;
    logic       sda_oe;
    logic [5:0] ctrl_out;
    logic       sda_bus;
    int         errors = 0;
    int         checks = 0;
    int         r9_viol = 0;
    logic       prev_oe = 1'b0;
    logic       done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    supply_ctl_i2c uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .supply_ok(supply_ok),
        .flag_hot(flag_hot), .flag_ovl(flag_ovl), .ctrl_out(ctrl_out)
    );

    // R9 monitor: drive must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_oe != prev_oe) r9_viol++;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic give_ack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~give_ack);
    endtask

    task automatic t_reset;
        chk("R7 ctrl after reset", {2'b0, ctrl_out}, 8'h00);
        chk("R7 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_basic_write;
        logic ack;
        addr_sel = 2'd0;
        bus_start;
        write_byte(8'h10, ack);
        chk("R1 R2 ack of write address 0x10", {7'b0, ack}, 8'h01);
        write_byte(8'hA7, ack);
        chk("R3 data ack", {7'b0, ack}, 8'h01);
        bus_stop;
        chk("R3 ctrl from bits 7:2", {2'b0, ctrl_out}, 8'h29);
    endtask

    task automatic t_basic_read;
        logic ack;
        logic [7:0] v;
        flag_hot = 1'b1; flag_ovl = 1'b0;
        bus_start;
        write_byte(8'h11, ack);
        chk("R2 ack of read address 0x11", {7'b0, ack}, 8'h01);
        read_byte(v, 1'b0);
        bus_stop;
        chk("R4 R3 read byte with live flags", v, 8'hA6);
    endtask

    task automatic t_select;
        logic ack;
        addr_sel = 2'd2;
        bus_start;
        write_byte(8'h10, ack);
        chk("R1 other address not acked", {7'b0, ack}, 8'h00);
        bus_stop;
        chk("R1 ctrl unchanged on mismatch", {2'b0, ctrl_out}, 8'h29);
        bus_start;
        write_byte(8'h14, ack);
        chk("R1 select 2 address acked", {7'b0, ack}, 8'h01);
        write_byte(8'h54, ack);
        bus_stop;
        chk("R1 write through select 2", {2'b0, ctrl_out}, 8'h15);
    endtask

    task automatic t_multi_write;
        logic ack;
        bus_start;
        write_byte(8'h14, ack);
        write_byte(8'h04, ack);
        chk("R10 first data byte", {2'b0, ctrl_out}, 8'h01);
        write_byte(8'hF8, ack);
        chk("R10 second data byte acked", {7'b0, ack}, 8'h01);
        chk("R10 second data byte", {2'b0, ctrl_out}, 8'h3E);
        bus_stop;
    endtask

    task automatic t_multi_read;
        logic ack, b;
        logic [7:0] v;
        flag_hot = 1'b0; flag_ovl = 1'b1;
        bus_start;
        write_byte(8'h15, ack);
        read_byte(v, 1'b1);
        chk("R5 first read byte", v, 8'hF9);
        read_byte(v, 1'b0);
        chk("R5 second byte after master ack", v, 8'hF9);
        recv_bit(b);
        chk("R5 released after master nack", {7'b0, b}, 8'h01);
        bus_stop;
    endtask

    task automatic t_restart;
        logic ack;
        bus_start;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start;
        write_byte(8'h14, ack);
        chk("R8 address after mid-byte start", {7'b0, ack}, 8'h01);
        write_byte(8'h08, ack);
        bus_stop;
        chk("R8 write after restart", {2'b0, ctrl_out}, 8'h02);
    endtask

    task automatic t_supply;
        logic ack;
        supply_ok = 1'b0; tick(4);
        chk("R6 ctrl cleared on low supply", {2'b0, ctrl_out}, 8'h00);
        bus_start;
        write_byte(8'h14, ack);
        chk("R6 no ack on low supply", {7'b0, ack}, 8'h00);
        write_byte(8'hFC, ack);
        bus_stop;
        chk("R6 ctrl held at zero", {2'b0, ctrl_out}, 8'h00);
        supply_ok = 1'b1; tick(4);
        bus_start;
        write_byte(8'h14, ack);
        write_byte(8'h80, ack);
        bus_stop;
        chk("R6 write after supply returns", {2'b0, ctrl_out}, 8'h20);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset;
        t_basic_write;
        t_basic_read;
        t_select;
        t_multi_write;
        t_multi_read;
        t_restart;
        t_supply;
        chk("R9 drive changes while SCL high", r9_viol[7:0], 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule